// File: doc/BRIEF.md
# Bit-Serial Accumulator Adder

This block adds two 4-bit unsigned numbers one bit position per clock. A parallel load places the first operand in an accumulator shift register and the second in an addend register, and clears the carry flip-flop. A one-cycle start pulse then launches four shift steps on four successive falling clock edges. On each step a full adder combines the low bits of both registers with the stored carry. The sum bit enters the top of the accumulator as it shifts right. The addend register rotates right onto itself, and the carry-out is held for the next step.

After the fourth step the accumulator holds the 4-bit sum, which replaces the first operand. The addend register is back at its loaded value, so it can be reused. A new start without a reload adds the kept addend again, together with the carry left by the previous run. That carry also appears as a separate overflow bit and is never folded into the 4-bit result. A busy output is high while a run is in progress. Loads and starts that arrive during a run are ignored.

All registers change only on the falling clock edge, and reset is asynchronous and active low.

Top module: `serial_acc_adder`

## Requirements
- R1: After reset, sum is 0, carry_out is 0 and busy is 0.
- R2: When idle (busy=0), a falling edge with load=1 copies x_in to the accumulator, so sum equals x_in after that edge. The same edge copies y_in to the addend register and clears carry_out to 0.
- R3: An idle falling edge with start=1 and load=0 starts a run of exactly four shift steps on four consecutive falling edges. busy goes high after the first step and low after the fourth, so it is high for three clock periods. The block then stays idle until the next start.
- R4: After a run, sum equals (A + Y + C) mod 16 and carry_out equals bit 4 of A + Y + C. Here A is the accumulator value, Y the addend value and C the carry_out value, all taken before the run.
- R5: The addend register keeps its loaded value across a run. A second start without a reload adds the same Y again, using the carry left by the previous run as the carry-in.
- R6: A load asserted while busy=1 has no effect: the result of the run in progress is unchanged.
- R7: When load and start are both 1 on the same idle edge, the load is performed and the start is ignored: busy stays 0 and sum equals x_in.
- R8: While idle, with load=0 and start=0, sum and carry_out keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Parallel load of both operands; used only while idle |
| x_in | input | 4 | Operand written into the accumulator |
| y_in | input | 4 | Operand written into the addend register |
| start | input | 1 | Launches a four-step addition when idle and not loading |
| busy | output | 1 | High while steps two to four are pending |
| sum | output | 4 | Parallel view of the accumulator |
| carry_out | output | 1 | Stored carry; after a run, the overflow of the addition |

## Verification
The in-module properties check the following on every falling edge. An idle load must leave sum equal to the loaded operand with a cleared carry. An accepted start must raise busy. The last step must drop busy. An idle cycle with no request must keep sum and carry_out unchanged. Only the bench scenarios can show arithmetic correctness over a whole run, the preservation of the addend across back-to-back runs, the carry chained into a following run, the exact busy length, and the rejection of loads during a run and of a start that collides with a load.

// File: rtl/serial_acc_adder.sv
module serial_acc_adder #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic         start,
  output logic         busy,
  output logic [N-1:0] sum,
  output logic         carry_out
);

  localparam int SW = $clog2(N);

  logic [N-1:0]  acc;
  logic [N-1:0]  addend;
  logic          cy;
  logic [SW-1:0] step;

  logic idle, do_load, shift, fa_s, fa_c;

  assign idle    = (step == '0);
  assign do_load = idle & load;
  assign shift   = ~idle | (start & ~load);

  assign fa_s = acc[0] ^ addend[0] ^ cy;
  assign fa_c = (acc[0] & addend[0]) | (cy & (acc[0] ^ addend[0]));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      addend <= '0;
      cy     <= 1'b0;
    end else if (do_load) begin
      acc    <= x_in;
      addend <= y_in;
      cy     <= 1'b0;
    end else if (shift) begin
      acc    <= {fa_s, acc[N-1:1]};
      addend <= {addend[0], addend[N-1:1]};
      cy     <= fa_c;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)     step <= '0;
    else if (shift) step <= step + 1'b1;
  end

  assign busy      = ~idle;
  assign sum       = acc;
  assign carry_out = cy;

  // R2
  load_capture_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (load && !busy) |=> (sum == $past(x_in)) && !carry_out);

  // R3
  run_begin_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (start && !load && !busy) |=> busy);

  // R3
  run_end_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (step == SW'(N-1)) |=> !busy);

  // R8
  idle_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!busy && !load && !start) |=> $stable(sum) && $stable(carry_out) && !busy);

endmodule

// File: tb/test_serial_acc_adder.sv
module test_serial_acc_adder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic       start = 1'b0;
  logic [3:0] x_in = '0;
  logic [3:0] y_in = '0;
  logic       busy;
  logic [3:0] sum;
  logic       carry_out;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [4:0] exp_q[$];
  logic [3:0] m_acc, m_y;
  logic       m_c;

  always #10 clk = ~clk;

  serial_acc_adder i_serial_acc_adder (
    .clk(clk), .rst_n(rst_n), .load(load), .x_in(x_in), .y_in(y_in),
    .start(start), .busy(busy), .sum(sum), .carry_out(carry_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [3:0] x, input logic [3:0] y);
    @(posedge clk);
    load = 1'b1; x_in = x; y_in = y;
    @(posedge clk);
    load = 1'b0;
    m_acc = x; m_y = y; m_c = 1'b0;
    check("R2 sum after load", {28'd0, sum}, {28'd0, x});
    check("R2 carry cleared", {31'd0, carry_out}, 32'd0);
  endtask

  task automatic push_expected();
    logic [4:0] t;
    t = {1'b0, m_acc} + {1'b0, m_y} + {4'd0, m_c};
    m_acc = t[3:0];
    m_c   = t[4];
    exp_q.push_back(t);
  endtask

  task automatic run_add(input bit poke_load);
    int busy_cnt;
    push_expected();
    @(posedge clk);
    start = 1'b1;
    @(posedge clk);
    start = 1'b0;
    busy_cnt = 0;
    if (poke_load) begin
      load = 1'b1; x_in = 4'h9; y_in = 4'h9;
    end
    while (busy && busy_cnt < 10) begin
      busy_cnt++;
      @(posedge clk);
      load = 1'b0;
    end
    check("R3 busy periods", busy_cnt, 3);
    repeat (3) @(posedge clk);
    check("R3 no extra shift sum", {28'd0, sum}, {28'd0, m_acc});
    check("R3 idle after run", {31'd0, busy}, 32'd0);
  endtask

  initial begin : monitor
    logic prev_busy;
    logic [4:0] e;
    prev_busy = 1'b0;
    forever begin
      @(posedge clk);
      if (prev_busy && !busy) begin
        if (exp_q.size() == 0) begin
          check("R4 unexpected result", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check("R4 R5 R6 result", {27'd0, carry_out, sum}, {27'd0, e});
        end
      end
      prev_busy = busy;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    #1;
    check("R1 reset sum", {28'd0, sum}, 32'd0);
    check("R1 reset carry", {31'd0, carry_out}, 32'd0);
    check("R1 reset busy", {31'd0, busy}, 32'd0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    do_load(4'b0101, 4'b0111);
    run_add(0);
    check("R4 example 0101+0111", {27'd0, carry_out, sum}, 32'b0_1100);
    run_add(0);
    check("R5 second run overflow", {27'd0, carry_out, sum}, 32'b1_0011);
    run_add(0);
    check("R5 carry chained", {27'd0, carry_out, sum}, 32'b0_1011);

    do_load(4'hF, 4'h1);
    run_add(0);
    check("R4 overflow", {27'd0, carry_out, sum}, 32'b1_0000);

    do_load(4'h3, 4'h6);
    run_add(1);
    check("R6 load while busy ignored", {27'd0, carry_out, sum}, 32'b0_1001);

    @(posedge clk);
    load = 1'b1; start = 1'b1; x_in = 4'hA; y_in = 4'h2;
    @(posedge clk);
    load = 1'b0; start = 1'b0;
    m_acc = 4'hA; m_y = 4'h2; m_c = 1'b0;
    check("R7 start with load ignored busy", {31'd0, busy}, 32'd0);
    check("R7 load performed", {28'd0, sum}, 32'hA);
    repeat (5) @(posedge clk);
    check("R8 idle hold sum", {28'd0, sum}, 32'hA);
    check("R8 idle hold carry", {31'd0, carry_out}, 32'd0);
    run_add(0);

    for (int i = 0; i < 6; i++) begin
      do_load(4'(i * 5 + 3), 4'(i * 7 + 9));
      run_add(0);
    end

    repeat (3) @(posedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule